// File: doc/BRIEF.md
# Filtered Quadrature Position Decoder

This block turns the two phase signals of an incremental shaft encoder into a signed position count. Every edge of either phase moves the count by one, so each full quadrature cycle gives four counts. All four inputs (phase A, phase B, index and home) first pass through a two-flop synchronizer. Each then passes through a run-length filter that accepts a new level only after it has held for a programmable number of samples. Short glitches never reach the counter. If both phases change in the same sample, the step is ambiguous: the count is left alone and a flag is raised.

Beside the position, the block keeps a difference count that is cleared each time it is read. Software reads it either at a fixed rate to measure speed on a fast shaft, or on a slow timer to catch single counts on a slow shaft. A no-motion watchdog raises an alarm when no count step occurs within a programmable number of cycles. Rising edges of index or home can clear the position, and each sets its own sticky flag.

Software reaches the control, position, difference, timeout and flag registers through a simple word bus with a one-cycle write strobe and a read strobe. Read data is combinational from the bus address.

Top module: `quad_decoder`

## Requirements
- R1: After reset, position, difference, direction, flags, control (address 0) and timeout (address 3) all read 0.
- R2: Each input passes through two synchronizer flops. A filtered level changes only after the synchronized input has differed from it on F+1 consecutive clock samples, where F is control bits [4 +: FLT_W]. A pulse shorter than that never changes the count or the flags.
- R3: The filtered phase pair {A,B} stepping through 00→01→11→10→00 adds one to the position for each step, and the reverse order subtracts one. The count changes on the same edge on which the filtered level is accepted.
- R4: If both filtered phases change on the same sample, flag bit 0 sets, the position and difference stay unchanged, and the direction output holds.
- R5: A rising edge of filtered index sets flag bit 1, and a rising edge of filtered home sets flag bit 2. The position becomes 0 on that edge if control bit 0 (for index) or control bit 1 (for home) is set. This clear takes priority over a bus load and over a count step.
- R6: A read strobe at address 2 returns the difference accumulated since the previous such read and clears it. A step on that same edge becomes the new difference.
- R7: With control bit 2 set and timeout T (address 3) nonzero, flag bit 3 sets after T+1 consecutive cycles without a count step. A step or a fired alarm restarts the interval.
- R8: Flags are sticky. Writing address 4 clears every flag whose data bit is 1. A flag that is set on the same edge stays set.
- R9: A write to address 1 loads the position. Counting wraps modulo 2^CNT_W in both directions.
- R10: The direction output shows the sense of the last count step (1 = up). Reads return control at address 0, the position sign-extended at 1, the difference sign-extended at 2, the timeout at 3 and the flags at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A |
| phase_b | input | 1 | Encoder phase B |
| index_in | input | 1 | Once-per-revolution index pulse |
| home_in | input | 1 | Home switch |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the difference at address 2) |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data |
| position | output | CNT_W | Signed position count |
| difference | output | CNT_W | Signed count change since last difference read |
| direction | output | 1 | Sense of last step, 1 = up |
| flags | output | 4 | Sticky flags: 0 illegal, 1 index, 2 home, 3 watchdog |

## Verification
The bench builds the decoder with CNT_W=8, FLT_W=3 and WD_W=8. An 8-bit position wraps after a few hundred steps, so wrap in both directions is reached quickly. A 3-bit filter field lets both the shortest filter and a three-sample filter be exercised. An 8-bit timeout keeps watchdog intervals short enough to trip and clear several times. A long pseudo-random phase sequence with the shortest filter produces simultaneous phase changes, index and home edges, and reads of the difference landing on the same edges as steps.

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4,
  parameter int WD_W  = 16,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic             home_in,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [CNT_W-1:0] position,
  output logic [CNT_W-1:0] difference,
  output logic             direction,
  output logic [3:0]       flags
);
  localparam logic [2:0] A_CTRL = 3'd0, A_POS = 3'd1, A_DIFF = 3'd2, A_TMO = 3'd3, A_FLAG = 3'd4;

  logic [3:0] sync1, sync2, filt, accept, filt_nx;
  logic [FLT_W-1:0] flt_len;
  logic idx_clr, home_clr, wd_en;
  logic [WD_W-1:0] wd_to, wd_cnt;
  logic [CNT_W-1:0] pos_q, diff_q;
  logic dir_q;
  logic [3:0] flag_q;

  for (genvar g = 0; g < 4; g++) begin : g_flt
    logic [FLT_W-1:0] run;
    assign accept[g] = (sync2[g] != filt[g]) && (run == flt_len);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) run <= '0;
      else if (sync2[g] == filt[g] || accept[g]) run <= '0;
      else run <= run + 1'b1;
  end

  assign filt_nx = filt ^ accept;

  wire illegal  = accept[0] & accept[1];
  wire stepped  = accept[0] ^ accept[1];
  wire step_up  = filt[0] ^ filt_nx[1];
  wire idx_rise = accept[2] & filt_nx[2];
  wire hom_rise = accept[3] & filt_nx[3];
  wire pos_clr  = (idx_rise & idx_clr) | (hom_rise & home_clr);
  wire pos_wr   = bus_wr && bus_addr == A_POS;
  wire diff_rd  = bus_rd && bus_addr == A_DIFF;
  wire flag_wr  = bus_wr && bus_addr == A_FLAG;
  wire wd_fire  = wd_en && !stepped && wd_to != '0 && wd_cnt == wd_to;
  wire [CNT_W-1:0] delta = stepped ? (step_up ? CNT_W'(1) : {CNT_W{1'b1}}) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; filt <= '0;
    end else begin
      sync1 <= {home_in, index_in, phase_b, phase_a};
      sync2 <= sync1;
      filt  <= filt_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_len <= '0; idx_clr <= 1'b0; home_clr <= 1'b0; wd_en <= 1'b0; wd_to <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        idx_clr  <= bus_wdata[0];
        home_clr <= bus_wdata[1];
        wd_en    <= bus_wdata[2];
        flt_len  <= bus_wdata[4 +: FLT_W];
      end
      if (bus_addr == A_TMO) wd_to <= bus_wdata[WD_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos_q <= '0; diff_q <= '0; dir_q <= 1'b0;
    end else begin
      if (pos_clr)     pos_q <= '0;
      else if (pos_wr) pos_q <= bus_wdata[CNT_W-1:0];
      else             pos_q <= pos_q + delta;
      diff_q <= diff_rd ? delta : diff_q + delta;
      if (stepped) dir_q <= step_up;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wd_cnt <= '0;
    else if (!wd_en || stepped || wd_to == '0 || wd_fire) wd_cnt <= '0;
    else wd_cnt <= wd_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else flag_q <= (flag_q & ~(flag_wr ? bus_wdata[3:0] : 4'h0))
                 | {wd_fire, hom_rise, idx_rise, illegal};

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = BUS_W'({flt_len, 1'b0, wd_en, home_clr, idx_clr});
      A_POS:   bus_rdata = BUS_W'($signed(pos_q));
      A_DIFF:  bus_rdata = BUS_W'($signed(diff_q));
      A_TMO:   bus_rdata = BUS_W'(wd_to);
      A_FLAG:  bus_rdata = BUS_W'(flag_q);
      default: bus_rdata = '0;
    endcase

  assign position   = pos_q;
  assign difference = diff_q;
  assign direction  = dir_q;
  assign flags      = flag_q;

  AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2 == filt) |=> $stable(filt)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stepped && !pos_clr && !pos_wr) |=>
      (position == $past(position) + CNT_W'(1) || position == $past(position) - CNT_W'(1))); // R3
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !pos_clr && !pos_wr) |=> ($stable(position) && flags[0])); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pos_clr |=> position == '0); // R5
  AST_DIFF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_rd && !stepped) |=> difference == '0); // R6
  AST_WD_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> flags[3]); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flags & $past(flags)) == $past(flags))); // R8
endmodule

// File: tb/quad_decoder_test.sv
module quad_decoder_test;
  localparam int PERIOD = 10;
  localparam int CW = 8, FW = 3, WW = 8, BW = 16;
  localparam int CMASK = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic pa = 0, pb = 0, pi = 0, ph = 0;
  logic [2:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [BW-1:0] bus_wdata = 0;
  logic [BW-1:0] bus_rdata;
  logic [CW-1:0] position, difference;
  logic direction;
  logic [3:0] flags;

  quad_decoder #(.CNT_W(CW), .FLT_W(FW), .WD_W(WW), .BUS_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb), .index_in(pi), .home_in(ph),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .position(position), .difference(difference),
    .direction(direction), .flags(flags));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // behavioural reference
  bit [3:0] m_s1, m_s2, m_f, m_acc, m_nf;
  int m_run[4];
  int m_flt, m_to, m_wd, mpos, mdiff;
  bit [2:0] m_ctl;
  bit mdir;
  bit [3:0] mflags;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_f = 0; m_flt = 0; m_to = 0; m_wd = 0;
      mpos = 0; mdiff = 0; m_ctl = 0; mdir = 0; mflags = 0;
      foreach (m_run[i]) m_run[i] = 0;
    end else begin
      bit ill, st, up, ir, hr, clr, fire;
      int d;
      for (int i = 0; i < 4; i++) begin
        m_acc[i] = (m_s2[i] != m_f[i]) && (m_run[i] == m_flt);
        if (m_s2[i] == m_f[i] || m_acc[i]) m_run[i] = 0; else m_run[i]++;
      end
      m_nf = m_f ^ m_acc;
      ill = m_acc[0] && m_acc[1];
      st  = m_acc[0] ^ m_acc[1];
      up  = m_f[0] ^ m_nf[1];
      ir  = m_acc[2] && m_nf[2];
      hr  = m_acc[3] && m_nf[3];
      clr = (ir && m_ctl[0]) || (hr && m_ctl[1]);
      d = st ? (up ? 1 : -1) : 0;
      if (clr) mpos = 0;
      else if (bus_wr && bus_addr == 1) mpos = int'(bus_wdata) & CMASK;
      else mpos = (mpos + d) & CMASK;
      if (bus_rd && bus_addr == 2) mdiff = d & CMASK; else mdiff = (mdiff + d) & CMASK;
      if (st) mdir = up;
      fire = 0;
      if (!m_ctl[2] || st || m_to == 0) m_wd = 0;
      else if (m_wd == m_to) begin fire = 1; m_wd = 0; end
      else m_wd++;
      if (bus_wr && bus_addr == 4) mflags = mflags & ~bus_wdata[3:0];
      mflags = mflags | {fire, hr, ir, ill};
      if (bus_wr && bus_addr == 0) begin m_ctl = bus_wdata[2:0]; m_flt = int'(bus_wdata[4 +: FW]); end
      if (bus_wr && bus_addr == 3) m_to = int'(bus_wdata[WW-1:0]);
      m_f = m_nf; m_s2 = m_s1; m_s1 = {ph, pi, pb, pa};
    end
  end

  function automatic logic [BW-1:0] exp_rdata(input logic [2:0] a);
    case (a)
      3'd0: return BW'({3'(m_flt), 1'b0, m_ctl});
      3'd1: return BW'($signed(CW'(mpos)));
      3'd2: return BW'($signed(CW'(mdiff)));
      3'd3: return BW'(m_to);
      3'd4: return BW'(mflags);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check("R3 R9 position", int'(position), mpos);
      check("R6 difference", int'(difference), mdiff);
      check("R10 direction", int'(direction), int'(mdir));
      check("R8 flags", int'(flags), int'(mflags));
      check("R10 bus_rdata", int'(bus_rdata), int'(exp_rdata(bus_addr)));
    end
    if (cyc > 100000 && !done) begin
      failures++;
      done = 1;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [BW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick(1);
    bus_wr = 0;
  endtask

  task automatic read_diff();
    bus_addr = 3'd2; bus_rd = 1;
    tick(1);
    bus_rd = 0;
  endtask

  int q = 0;
  task automatic step(input bit fwd, input int hold);
    q = fwd ? (q + 1) % 4 : (q + 3) % 4;
    pa = q[1]; pb = q[1] ^ q[0];
    tick(hold);
  endtask

  initial begin
    logic [15:0] lfsr;
    int p0;
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    check("R1 reset position", int'(position), 0);
    check("R1 reset flags", int'(flags), 0);
    check("R1 reset direction", int'(direction), 0);
    bus_addr = 3'd0; #1;
    check("R1 reset control", int'(bus_rdata), 0);

    bus_write(3'd0, 16'h0020); // filter F=2
    for (int i = 0; i < 8; i++) step(1, 6);
    check("R3 forward eight steps", int'(position), 8);
    for (int i = 0; i < 3; i++) step(0, 6);
    check("R3 reverse three steps", int'(position), 5);
    check("R10 direction down", int'(direction), 0);

    // R2: two-sample glitch is filtered out, three samples pass
    p0 = int'(position);
    pa = ~pa; tick(2); pa = ~pa; tick(8);
    check("R2 glitch ignored", int'(position), p0);
    q = (q + 1) % 4; pa = q[1]; pb = q[1] ^ q[0]; tick(3); q = (q + 3) % 4; pa = q[1]; pb = q[1] ^ q[0]; tick(8);
    check("R2 three-sample pulse counted back", int'(position), p0);

    // R4 both phases flip at once
    p0 = int'(position);
    pa = ~pa; pb = ~pb; q = (q + 2) % 4; tick(8);
    check("R4 illegal position held", int'(position), p0);
    check("R4 illegal flag", int'(flags[0]), 1);

    // R6 difference read clears
    read_diff();
    check("R6 difference after read", int'(difference), 0);
    step(1, 6); step(1, 6);
    check("R6 difference counts again", int'(difference), 2);

    // R5 index clears when enabled; home only flags
    bus_write(3'd0, 16'h0021);
    pi = 1; tick(8); pi = 0; tick(6);
    check("R5 index clears position", int'(position), 0);
    check("R5 index flag", int'(flags[1]), 1);
    step(1, 6);
    ph = 1; tick(8); ph = 0; tick(6);
    check("R5 home without enable keeps position", int'(position), 1);
    check("R5 home flag", int'(flags[2]), 1);

    // R8 write-one-to-clear
    bus_write(3'd4, 16'h0002);
    check("R8 partial clear", int'(flags), 4'b0101);
    bus_write(3'd4, 16'h000F);
    check("R8 full clear", int'(flags), 0);

    // R7 watchdog
    bus_write(3'd3, 16'd20);
    bus_write(3'd0, 16'h0024);
    tick(10);
    check("R7 no alarm yet", int'(flags[3]), 0);
    tick(20);
    check("R7 alarm after timeout", int'(flags[3]), 1);
    bus_write(3'd4, 16'h0008);
    for (int i = 0; i < 10; i++) step(1, 6);
    check("R7 motion keeps alarm clear", int'(flags[3]), 0);

    // R9 load and wrap
    bus_write(3'd1, 16'h00FF);
    step(1, 6);
    check("R9 wrap up", int'(position), 0);
    step(0, 6);
    check("R9 wrap down", int'(position), 255);
    bus_addr = 3'd1; #1;
    check("R10 sign-extended read", int'(bus_rdata), 16'hFFFF);

    // fast pseudo-random run, shortest filter, clears enabled
    bus_write(3'd0, 16'h0007);
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd1) pa = ~pa;
      if (lfsr[5:3] == 3'd2) pb = ~pb;
      if (lfsr[9:6] == 4'd3) pa = ~pa;
      if (lfsr[11:8] == 4'd5) pi = ~pi;
      if (lfsr[15:12] == 4'd9) ph = ~ph;
      bus_addr = lfsr[14:12] % 5;
      bus_rd = lfsr[7] & lfsr[1];
      bus_wr = (lfsr[10:6] == 5'd17);
      bus_wdata = {8'h00, lfsr[15:8]};
      if (bus_wr && bus_addr == 0) bus_wdata = 16'h0007;
      if (bus_wr && bus_addr == 3) bus_wdata = 16'd12;
      tick(1);
    end
    bus_wr = 0; bus_rd = 0;
    tick(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule